// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block produces the branch metrics that feed the add-compare-select stage of a 64-state, rate-1/2 trellis decoder. The code has constraint length 7 and generators 171 and 133 in octal. The block accepts one received soft pair per trellis step. Each symbol is a 3-bit unsigned sample, where level 0 stands for a transmitted 0 and level 7 stands for a transmitted 1. The block then sweeps the 64 trellis states, one state per clock. For every state it presents two metrics: one for the branch that assumes input 0 and one for the branch that assumes input 1. Each metric is the squared Euclidean distance between the received pair and the code pair that the branch would emit.

The block couples to the path metric stage through a four-phase exchange. A decoder enable starts a sweep. When the sweep completes, the block raises its ready flag and an enable toward the next stage. The next stage returns its own ready, and that clears the flag so that the block can accept a new pair. When the decoder enable falls, the enable toward the next stage falls too.

The four squared terms are derived once from the captured pair. Each state then only selects two of these terms through its code bits and adds them.

Top module: `sd_branch_metric`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `met_valid`, `bm_ready` and `pm_enable` are 0 until a sweep runs.
- R2: A sweep starts at a rising edge that samples `en_in` high while no sweep is running and `bm_ready` is low. At the next edge, `met_valid` rises with `met_state` = 0. `met_state` then counts up by one per edge to 63, and `met_valid` stays high for exactly 64 cycles.
- R3: The expected code pair for state s and assumed input u is computed as follows. Bit c1 is u ^ s[5] ^ s[4] ^ s[3] ^ s[0]. Bit c2 is u ^ s[4] ^ s[3] ^ s[1] ^ s[0]. Examples: state 0 gives 00 (u=0) and 11 (u=1); state 1 gives 11 and 00; state 2 gives 01 and 10.
- R4: The metric is (ra − 7·c1)² + (rb − 7·c2)², where ra is `sym_a` and rb is `sym_b`. `met_zero` carries the u=0 metric and `met_one` carries the u=1 metric. No value exceeds 98.
- R5: The symbol pair is captured on the start edge. Changes to `sym_a` or `sym_b` during a sweep have no effect on that sweep's metrics.
- R6: `bm_ready` and `pm_enable` rise on the same edge that presents state 63. `bm_ready` stays low while states 0 to 62 are presented.
- R7: `bm_ready` stays high until `pm_ready` is sampled high. It clears at that edge, after which a new sweep may start.
- R8: `pm_enable` falls at the edge that samples `en_in` low. It is not raised by a sweep that completes while `en_in` is low.
- R9: While `bm_ready` is high, a high `en_in` starts no sweep, and `met_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| en_in | input | 1 | Decoder enable: a received pair is waiting |
| sym_a | input | 3 | First soft symbol of the received pair |
| sym_b | input | 3 | Second soft symbol of the received pair |
| pm_ready | input | 1 | Path metric stage has taken the metrics |
| met_valid | output | 1 | Metric outputs hold the values for `met_state` |
| met_state | output | 6 | Trellis state that the metrics belong to |
| met_zero | output | 7 | Metric of the input-0 branch |
| met_one | output | 7 | Metric of the input-1 branch |
| bm_ready | output | 1 | Sweep complete, waiting for `pm_ready` |
| pm_enable | output | 1 | Enable toward the path metric stage |

## Verification
The results for state s appear s+1 edges after the start edge. Both `bm_ready` and `pm_enable` are due on the 64th edge after the start edge. `bm_ready` clears one edge after `pm_ready` is seen, and `pm_enable` falls one edge after `en_in` is seen low. The bench drives its inputs and samples the outputs on falling edges only, so each check lands exactly one half period after the edge that is due to produce its value. The bench disturbs the symbol inputs straight after the start edge to show that they are ignored.

// File: rtl/sdbm_pkg.sv
// Package: shared phase encoding for the branch metric unit controller.
// Assumes: used by bmu_ctrl only; values carry no external meaning.
package sdbm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SWEEP = 2'd1,
        PH_HOLD  = 2'd2
    } bmu_phase_t;
endpackage

// File: rtl/bmu_ctrl.sv
// Module: bmu_ctrl
// Sequences one sweep over all trellis states and runs the four-phase
// coupling to the path metric stage.
// Assumes: one state per clock; start needs idle phase and high enable.
module bmu_ctrl #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic             pm_ready,
    output logic             load,
    output logic             sweep,
    output logic [IDX_W-1:0] idx,
    output logic             hold,
    output logic             pm_en
);
    import sdbm_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    bmu_phase_t phase;
    logic       last;

    assign load  = (phase == PH_IDLE) && en_in;
    assign sweep = (phase == PH_SWEEP);
    assign hold  = (phase == PH_HOLD);
    assign last  = sweep && (idx == LAST_IDX);

    // Phase register: idle -> sweep -> hold -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:  if (en_in)    phase <= PH_SWEEP;
                PH_SWEEP: if (last)     phase <= PH_HOLD;
                PH_HOLD:  if (pm_ready) phase <= PH_IDLE;
                default:                phase <= PH_IDLE;
            endcase
        end
    end

    // State index counter for the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx <= '0;
        else if (load)  idx <= '0;
        else if (sweep) idx <= idx + 1'b1;
    end

    // Downstream enable: set at sweep end, held only while en_in stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) pm_en <= 1'b0;
        else        pm_en <= en_in && (pm_en || last);
    end
endmodule

// File: rtl/bmu_code_gen.sv
// Module: bmu_code_gen
// Expected code pair of one trellis branch: parity of the encoder window
// {assumed input, state} masked by each generator.
// Assumes: state MSB is the most recent input; generator MSB taps the input.
module bmu_code_gen #(
    parameter int             K   = 7,
    parameter logic [K-1:0]   G_A = 'o171,
    parameter logic [K-1:0]   G_B = 'o133
) (
    input  logic [K-2:0] state,
    input  logic         u,
    output logic [1:0]   code
);
    logic [K-1:0] window;

    // Parity of the window under each generator mask.
    always_comb begin
        window  = {u, state};
        code[1] = ^(window & G_A);
        code[0] = ^(window & G_B);
    end
endmodule

// File: rtl/bmu_sq_pair.sv
// Module: bmu_sq_pair
// Squared distances of one soft symbol to both ideal levels (0 and full scale).
// Assumes: unsigned symbol; full-scale minus symbol equals its bitwise inverse.
module bmu_sq_pair #(
    parameter int SYM_W = 3,
    localparam int SQ_W = 2 * SYM_W
) (
    input  logic [SYM_W-1:0] sym,
    output logic [SQ_W-1:0]  sq_near,
    output logic [SQ_W-1:0]  sq_far
);
    logic [SYM_W-1:0] dist_far;

    // Both squares from the symbol and its distance to full scale.
    always_comb begin
        dist_far = ~sym;
        sq_near  = SQ_W'(sym) * SQ_W'(sym);
        sq_far   = SQ_W'(dist_far) * SQ_W'(dist_far);
    end
endmodule

// File: rtl/sd_branch_metric.sv
// Module: sd_branch_metric (top)
// Soft-decision branch metric unit: captures a received pair, then emits the
// input-0 and input-1 squared Euclidean metrics for every state, one per clock.
// Assumes: rate-1/2 code, bit 0 at level 0, bit 1 at full scale.
module sd_branch_metric #(
    parameter int              SYM_W = 3,
    parameter int              K     = 7,
    parameter logic [K-1:0]    G_A   = 'o171,
    parameter logic [K-1:0]    G_B   = 'o133,
    localparam int             ST_W  = K - 1,
    localparam int             MET_W = 2 * SYM_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic [SYM_W-1:0] sym_a,
    input  logic [SYM_W-1:0] sym_b,
    input  logic             pm_ready,
    output logic             met_valid,
    output logic [ST_W-1:0]  met_state,
    output logic [MET_W-1:0] met_zero,
    output logic [MET_W-1:0] met_one,
    output logic             bm_ready,
    output logic             pm_enable
);
    localparam int SQ_W = 2 * SYM_W;

    logic             load;
    logic             sweep;
    logic [ST_W-1:0]  idx;
    logic [SYM_W-1:0] sym_q   [2];
    logic [SQ_W-1:0]  sq_near [2];
    logic [SQ_W-1:0]  sq_far  [2];
    logic [MET_W-1:0] met_c   [2];

    bmu_ctrl #(.IDX_W(ST_W)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_in    (en_in),
        .pm_ready (pm_ready),
        .load     (load),
        .sweep    (sweep),
        .idx      (idx),
        .hold     (bm_ready),
        .pm_en    (pm_enable)
    );

    // Capture the received pair on the start edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q[0] <= '0;
            sym_q[1] <= '0;
        end else if (load) begin
            sym_q[0] <= sym_a;
            sym_q[1] <= sym_b;
        end
    end

    for (genvar gs = 0; gs < 2; gs++) begin : g_sym
        bmu_sq_pair #(.SYM_W(SYM_W)) i_sq (
            .sym     (sym_q[gs]),
            .sq_near (sq_near[gs]),
            .sq_far  (sq_far[gs])
        );
    end

    for (genvar gu = 0; gu < 2; gu++) begin : g_branch
        logic [1:0] code;

        bmu_code_gen #(.K(K), .G_A(G_A), .G_B(G_B)) i_code (
            .state (idx),
            .u     (1'(gu)),
            .code  (code)
        );

        // Select each term by its code bit and add the pair.
        always_comb begin
            met_c[gu] = MET_W'(code[1] ? sq_far[0] : sq_near[0])
                      + MET_W'(code[0] ? sq_far[1] : sq_near[1]);
        end
    end

    // Registered metric outputs, one state per clock during a sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            met_valid <= 1'b0;
            met_state <= '0;
            met_zero  <= '0;
            met_one   <= '0;
        end else begin
            met_valid <= sweep;
            if (sweep) begin
                met_state <= idx;
                met_zero  <= met_c[0];
                met_one   <= met_c[1];
            end
        end
    end
endmodule

// File: rtl/bmu_checker.sv
// Module: bmu_checker
// Temporal properties of the branch metric unit ports, bound to the top.
// Assumes: synchronous active-low reset; all checks disabled during reset.
module bmu_checker #(
    parameter int SYM_W = 3,
    parameter int ST_W  = 6,
    parameter int MET_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_in,
    input logic             pm_ready,
    input logic             met_valid,
    input logic [ST_W-1:0]  met_state,
    input logic [MET_W-1:0] met_zero,
    input logic [MET_W-1:0] met_one,
    input logic             bm_ready,
    input logic             pm_enable
);
    localparam int           FULL  = (1 << SYM_W) - 1;
    localparam int           MAXM  = 2 * FULL * FULL;
    localparam logic [ST_W-1:0] TOP_ST = '1;

    AST_STATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        met_valid && $past(met_valid) |-> met_state == $past(met_state) + 1'b1); // R2

    AST_FIRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(met_valid) |-> met_state == '0); // R2

    AST_METRIC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        met_valid |-> (int'(met_zero) <= MAXM) && (int'(met_one) <= MAXM)); // R4

    AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bm_ready) |-> met_valid && met_state == TOP_ST); // R6

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bm_ready && !pm_ready |=> bm_ready); // R7

    AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bm_ready && pm_ready |=> !bm_ready); // R7

    AST_PM_EN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in |=> !pm_enable); // R8

    AST_NO_SWEEP_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bm_ready && $past(bm_ready) |-> !met_valid); // R9
endmodule

bind sd_branch_metric bmu_checker #(
    .SYM_W (SYM_W),
    .ST_W  (ST_W),
    .MET_W (MET_W)
) i_bmu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_in     (en_in),
    .pm_ready  (pm_ready),
    .met_valid (met_valid),
    .met_state (met_state),
    .met_zero  (met_zero),
    .met_one   (met_one),
    .bm_ready  (bm_ready),
    .pm_enable (pm_enable)
);

// File: tb/test_sd_branch_metric.sv
`timescale 1ns/1ps
// Bench for sd_branch_metric: directed corner pairs plus seeded random pairs,
// each swept over all 64 states against an independent encoder model.
module test_sd_branch_metric;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_in = 1'b0;
    logic [2:0] sa = '0;
    logic [2:0] sb = '0;
    logic       pm_ready = 1'b0;
    logic       met_valid;
    logic [5:0] met_state;
    logic [6:0] met_zero;
    logic [6:0] met_one;
    logic       bm_ready;
    logic       pm_enable;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sd_branch_metric i_sd_branch_metric (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_in     (en_in),
        .sym_a     (sa),
        .sym_b     (sb),
        .pm_ready  (pm_ready),
        .met_valid (met_valid),
        .met_state (met_state),
        .met_zero  (met_zero),
        .met_one   (met_one),
        .bm_ready  (bm_ready),
        .pm_enable (pm_enable)
    );

    // Encoder output model for state s, assumed input u (R3).
    function automatic int code_bits(input int s, input int u);
        int c1, c2;
        c1 = u ^ ((s >> 5) & 1) ^ ((s >> 4) & 1) ^ ((s >> 3) & 1) ^ (s & 1);
        c2 = u ^ ((s >> 4) & 1) ^ ((s >> 3) & 1) ^ ((s >> 1) & 1) ^ (s & 1);
        return c1 * 2 + c2;
    endfunction

    // Squared Euclidean metric against levels 0 / 7 (R4).
    function automatic int exp_metric(input int a, input int b, input int s, input int u);
        int cb, da, db;
        cb = code_bits(s, u);
        da = a - 7 * (cb >> 1);
        db = b - 7 * (cb & 1);
        return da * da + db * db;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sweep(input int a, input int b, input bit drop_en);
        @(negedge clk);
        sa = 3'(a); sb = 3'(b); en_in = 1'b1;
        @(negedge clk);                      // start edge has passed
        chk(met_valid == 1'b0, "R2", int'(met_valid), 0);
        sa = 3'($urandom % 8); sb = 3'($urandom % 8);   // R5: disturb inputs
        if (drop_en) en_in = 1'b0;
        for (int s = 0; s < 64; s++) begin
            @(negedge clk);
            chk(met_valid == 1'b1, "R2", int'(met_valid), 1);
            chk(int'(met_state) == s, "R2", int'(met_state), s);
            chk(int'(met_zero) == exp_metric(a, b, s, 0), "R4", int'(met_zero), exp_metric(a, b, s, 0));
            chk(int'(met_one) == exp_metric(a, b, s, 1), "R3", int'(met_one), exp_metric(a, b, s, 1));
            if (s < 63) chk(bm_ready == 1'b0, "R6", int'(bm_ready), 0);
        end
        chk(bm_ready == 1'b1, "R6", int'(bm_ready), 1);
        chk(pm_enable == !drop_en, "R8", int'(pm_enable), int'(!drop_en));
        en_in = 1'b1;
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            chk(met_valid == 1'b0, "R9", int'(met_valid), 0);
            chk(bm_ready == 1'b1, "R7", int'(bm_ready), 1);
            chk(pm_enable == !drop_en, "R8", int'(pm_enable), int'(!drop_en));
        end
        pm_ready = 1'b1;
        @(negedge clk);
        chk(bm_ready == 1'b0, "R7", int'(bm_ready), 1'b0);
        pm_ready = 1'b0; en_in = 1'b0;
        @(negedge clk);
        chk(pm_enable == 1'b0, "R8", int'(pm_enable), 0);
        chk(met_valid == 1'b0, "R7", int'(met_valid), 0);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        chk(met_valid == 1'b0, "R1", int'(met_valid), 0);
        chk(bm_ready == 1'b0, "R1", int'(bm_ready), 0);
        chk(pm_enable == 1'b0, "R1", int'(pm_enable), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(met_valid == 1'b0 && bm_ready == 1'b0, "R1", int'(met_valid), 0);
        // Directed corners: both levels ideal, and each mixed extreme.
        sweep(0, 0, 1'b0);
        sweep(7, 7, 1'b0);
        sweep(0, 7, 1'b0);
        sweep(7, 0, 1'b1);
        sweep(3, 4, 1'b0);
        // Random pairs.
        for (int n = 0; n < 8; n++) begin
            sweep(int'($urandom % 8), int'($urandom % 8), n[0]);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule